// File: doc/BRIEF.md
# Two-Stage Flash Thermometer Encoder

This block sits behind the comparator bank of an 8-bit flash converter. Each clock it takes one full sample: 256 comparator outputs, which rise with threshold, plus two extra comparators that detect an input below or above the converter's range. It reduces that sample to an 8-bit binary code with an underflow flag and an overflow flag. It accepts a new sample every clock. A valid strobe travels through the pipeline beside the data.

The comparator vector is handled as two identical halves of 128 taps each. In the first stage, each half splits its taps into four interleaved phases. A phase holds every fourth tap. The stage counts the asserted taps of each phase and packs the four counts into a compact intermediate word. In the second stage, the phase counts are added up for each half. The final code comes from the upper half when that half has any asserted tap; otherwise it comes from the lower half. The code is found by counting asserted taps rather than by finding the highest one. As a result, a stray comparator that switched in the wrong order moves the code by one step instead of causing a large jump.

Top module: `flash_thermo_encoder`

## Requirements
- R1: While reset is held and right after it, codeOut is 0x00, underFlag and overFlag are 0 and codeVld is 0.
- R2: A sample presented with sampleVld high at a rising edge produces its result with codeVld high after the third rising edge from that one. Samples on consecutive clocks produce results on consecutive clocks, in order.
- R3: Bit i of compIn is the comparator for threshold i, with bit 0 the lowest. For a clean thermometer of n set low bits (0 to 255), codeOut equals n. All 256 bits set gives 0xFF.
- R4: When any bit of compIn[255:128] is set, codeOut is 128 plus the number of set bits in that upper half, capped at 0xFF, whatever the lower half holds.
- R5: When the upper half is all zero, codeOut equals the number of set bits in compIn[127:0].
- R6: A single bubble inside a half, either one cleared bit below the transition or one set bit above it, moves codeOut by exactly one code from the clean value.
- R7: underIn high with overIn low forces codeOut to 0x00 with underFlag 1 and overFlag 0.
- R8: overIn high forces codeOut to 0xFF with overFlag 1 and underFlag 0, even when underIn is also high.
- R9: On clocks with no valid result, codeOut and both flags hold their last values, whatever is on compIn, underIn and overIn.
- R10: Within one half, swapping the states of two comparators (an out-of-order pair) does not change codeOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleVld | input | 1 | The comparator inputs carry a sample this clock |
| compIn | input | 256 | Comparator outputs, bit i for threshold i |
| underIn | input | 1 | Below-range comparator |
| overIn | input | 1 | Above-range comparator |
| codeOut | output | 8 | Binary sample code |
| underFlag | output | 1 | Result was below range |
| overFlag | output | 1 | Result was above range |
| codeVld | output | 1 | codeOut and the flags carry a new result |

## Verification
The hardest case to reach is a corrupted thermometer at a place where the two encoding stages interact. Examples are a stray set bit in the upper half while the lower half is only partly filled, or an out-of-order pair split across two interleave phases. Random vectors almost never form clean thermometers with exactly one defect, so the bench builds them on purpose. It makes a clean thermometer of chosen length and then flips or swaps single chosen bits: on both sides of the half boundary, and on taps that belong to different phases. Throughput is covered by streaming three such vectors back to back and matching each result to its own clock.

// File: rtl/flash_enc_pkg.sv
package flash_enc_pkg;
  // Load strobes from control to datapath, one per pipeline register rank.
  typedef struct packed {
    logic capLd;  // capture comparator sample
    logic midLd;  // load intermediate phase counts
    logic outLd;  // load final code and flags
  } encStrobe_t;
endpackage

// File: rtl/flash_enc_half.sv
module flash_enc_half #(
  parameter int TAPS       = 128,
  parameter int INTERLEAVE = 4
) (
  input  logic [TAPS-1:0]                                        taps,
  output logic [INTERLEAVE*$clog2(TAPS/INTERLEAVE+1)-1:0]        midWord
);
  localparam int PH_TAPS = TAPS / INTERLEAVE;
  localparam int PH_CW   = $clog2(PH_TAPS + 1);

  // One counter per interleave phase: phase p owns taps p, p+INTERLEAVE, ...
  for (genvar p = 0; p < INTERLEAVE; p++) begin : g_phase
    logic [PH_CW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int k = 0; k < PH_TAPS; k++) begin
        acc = acc + PH_CW'(taps[p + INTERLEAVE*k]);
      end
    end
    assign midWord[p*PH_CW +: PH_CW] = acc;
  end
endmodule

// File: rtl/flash_enc_ctrl.sv
module flash_enc_ctrl
  import flash_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleVld,
  output encStrobe_t strb,
  output logic       codeVld
);
  logic vldCap;
  logic vldMid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vldCap  <= 1'b0;
      vldMid  <= 1'b0;
      codeVld <= 1'b0;
    end else begin
      vldCap  <= sampleVld;
      vldMid  <= vldCap;
      codeVld <= vldMid;
    end
  end

  assign strb.capLd = sampleVld;
  assign strb.midLd = vldCap;
  assign strb.outLd = vldMid;
endmodule

// File: rtl/flash_enc_dp.sv
module flash_enc_dp
  import flash_enc_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int INTERLEAVE = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  encStrobe_t                strb,
  input  logic [(1<<CODE_W)-1:0]    compIn,
  input  logic                      underIn,
  input  logic                      overIn,
  output logic [CODE_W-1:0]         codeOut,
  output logic                      underFlag,
  output logic                      overFlag
);
  localparam int COMP_W  = 1 << CODE_W;
  localparam int HALF_W  = COMP_W / 2;
  localparam int PH_TAPS = HALF_W / INTERLEAVE;
  localparam int PH_CW   = $clog2(PH_TAPS + 1);
  localparam int MID_W   = INTERLEAVE * PH_CW;
  localparam int HALF_CW = $clog2(HALF_W + 1);

  // Rank 0: comparator capture
  logic [COMP_W-1:0] compReg;
  logic              undCap, ovrCap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      compReg <= '0;
      undCap  <= 1'b0;
      ovrCap  <= 1'b0;
    end else if (strb.capLd) begin
      compReg <= compIn;
      undCap  <= underIn;
      ovrCap  <= overIn;
    end
  end

  // Rank 1: intermediate phase-count words, one per half
  logic [MID_W-1:0]   midComb [2];
  logic [MID_W-1:0]   midReg  [2];
  logic [HALF_CW-1:0] halfCnt [2];
  logic               undMid, ovrMid;

  for (genvar h = 0; h < 2; h++) begin : g_half
    flash_enc_half #(
      .TAPS       (HALF_W),
      .INTERLEAVE (INTERLEAVE)
    ) u_half (
      .taps    (compReg[h*HALF_W +: HALF_W]),
      .midWord (midComb[h])
    );

    always_ff @(posedge clk) begin
      if (!rstN)           midReg[h] <= '0;
      else if (strb.midLd) midReg[h] <= midComb[h];
    end

    always_comb begin
      halfCnt[h] = '0;
      for (int p = 0; p < INTERLEAVE; p++) begin
        halfCnt[h] = halfCnt[h] + HALF_CW'(midReg[h][p*PH_CW +: PH_CW]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      undMid <= 1'b0;
      ovrMid <= 1'b0;
    end else if (strb.midLd) begin
      undMid <= undCap;
      ovrMid <= ovrCap;
    end
  end

  // Rank 2: half select, saturation and range override
  logic [CODE_W:0]   mergeRaw;
  logic [CODE_W-1:0] mergeCode;

  always_comb begin
    if (halfCnt[1] != '0)
      mergeRaw = (CODE_W+1)'(HALF_W) + (CODE_W+1)'(halfCnt[1]);
    else
      mergeRaw = (CODE_W+1)'(halfCnt[0]);
    mergeCode = mergeRaw[CODE_W] ? '1 : mergeRaw[CODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeOut   <= '0;
      underFlag <= 1'b0;
      overFlag  <= 1'b0;
    end else if (strb.outLd) begin
      if (ovrMid) begin
        codeOut   <= '1;
        overFlag  <= 1'b1;
        underFlag <= 1'b0;
      end else if (undMid) begin
        codeOut   <= '0;
        overFlag  <= 1'b0;
        underFlag <= 1'b1;
      end else begin
        codeOut   <= mergeCode;
        overFlag  <= 1'b0;
        underFlag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flash_thermo_encoder.sv
module flash_thermo_encoder
  import flash_enc_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int INTERLEAVE = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleVld,
  input  logic [(1<<CODE_W)-1:0]  compIn,
  input  logic                    underIn,
  input  logic                    overIn,
  output logic [CODE_W-1:0]       codeOut,
  output logic                    underFlag,
  output logic                    overFlag,
  output logic                    codeVld
);
  encStrobe_t strb;

  flash_enc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sampleVld (sampleVld),
    .strb      (strb),
    .codeVld   (codeVld)
  );

  flash_enc_dp #(
    .CODE_W     (CODE_W),
    .INTERLEAVE (INTERLEAVE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .compIn    (compIn),
    .underIn   (underIn),
    .overIn    (overIn),
    .codeOut   (codeOut),
    .underFlag (underFlag),
    .overFlag  (overFlag)
  );
endmodule

// File: rtl/flash_thermo_encoder_chk.sv
module flash_thermo_encoder_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleVld,
  input logic [CODE_W-1:0] codeOut,
  input logic              underFlag,
  input logic              overFlag,
  input logic              codeVld
);
  logic [1:0] cyc;

  always_ff @(posedge clk) begin
    if (!rstN)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (cyc == 2'd3) |-> (codeVld == $past(sampleVld, 3))); // R2

  AST_UNDER_CODE: assert property (@(posedge clk) disable iff (!rstN)
    underFlag |-> (codeOut == '0)); // R7

  AST_OVER_CODE: assert property (@(posedge clk) disable iff (!rstN)
    overFlag |-> (codeOut == '1)); // R8

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(underFlag && overFlag)); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ((cyc != 2'd0) && !codeVld) |-> ($stable(codeOut) && $stable(underFlag) && $stable(overFlag))); // R9
endmodule

bind flash_thermo_encoder flash_thermo_encoder_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sampleVld (sampleVld),
  .codeOut   (codeOut),
  .underFlag (underFlag),
  .overFlag  (overFlag),
  .codeVld   (codeVld)
);

// File: tb/flash_thermo_encoder_tb.sv
module flash_thermo_encoder_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         sampleVld = 1'b0;
  logic [255:0] compIn = '0;
  logic         underIn = 1'b0;
  logic         overIn = 1'b0;
  logic [7:0]   codeOut;
  logic         underFlag, overFlag, codeVld;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_thermo_encoder u_dut (
    .clk(clk), .rstN(rstN), .sampleVld(sampleVld), .compIn(compIn),
    .underIn(underIn), .overIn(overIn), .codeOut(codeOut),
    .underFlag(underFlag), .overFlag(overFlag), .codeVld(codeVld)
  );

  function automatic logic [255:0] therm(int n);
    logic [255:0] v = '0;
    for (int i = 0; i < n; i++) v[i] = 1'b1;
    return v;
  endfunction

  // Expected code from the requirements (R3, R4, R5, R7, R8)
  function automatic logic [7:0] expCode(logic [255:0] c, logic u, logic o);
    int cu = 0;
    int cl = 0;
    int r;
    if (o) return 8'hFF;
    if (u) return 8'h00;
    for (int i = 0; i < 128; i++) begin
      cl += int'(c[i]);
      cu += int'(c[128+i]);
    end
    r = (cu != 0) ? 128 + cu : cl;
    if (r > 255) r = 255;
    return 8'(r);
  endfunction

  task automatic checkOut(string tag, logic [7:0] eCode, logic eU, logic eO, logic eV);
    checks++;
    if (codeOut !== eCode || underFlag !== eU || overFlag !== eO || codeVld !== eV) begin
      errors++;
      $display("FAIL %s: code=%h under=%b over=%b vld=%b expected code=%h under=%b over=%b vld=%b",
               tag, codeOut, underFlag, overFlag, codeVld, eCode, eU, eO, eV);
    end
  endtask

  // One sample, checked three edges later, then held while garbage is idle (R9)
  task automatic runOne(string tag, logic [255:0] c, logic u, logic o);
    logic [7:0] e = expCode(c, u, o);
    @(negedge clk);
    compIn = c; underIn = u; overIn = o; sampleVld = 1'b1;
    @(negedge clk);
    sampleVld = 1'b0; compIn = ~c; underIn = ~u; overIn = ~o;
    @(negedge clk);
    @(negedge clk);
    checkOut(tag, e, u & ~o, o, 1'b1);
    @(negedge clk);
    checkOut({tag, " R9 hold"}, e, u & ~o, o, 1'b0);
    compIn = '0; underIn = 1'b0; overIn = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    checkOut("R1 during reset", 8'h00, 1'b0, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 after reset", 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_ideal();
    runOne("R3 n=0",    therm(0),   1'b0, 1'b0);
    runOne("R5 n=1",    therm(1),   1'b0, 1'b0);
    runOne("R5 n=127",  therm(127), 1'b0, 1'b0);
    runOne("R3 n=128",  therm(128), 1'b0, 1'b0);
    runOne("R3 n=129",  therm(129), 1'b0, 1'b0);
    runOne("R3 n=200",  therm(200), 1'b0, 1'b0);
    runOne("R3 n=255",  therm(255), 1'b0, 1'b0);
    runOne("R3 n=256 saturate", therm(256), 1'b0, 1'b0);
  endtask

  task automatic t_upper();
    logic [255:0] v = '0;
    v[130] = 1'b1;
    runOne("R4 lone upper bit", v, 1'b0, 1'b0);           // expect 129
    v = therm(40); v[128] = 1'b1; v[131] = 1'b1;
    runOne("R4 partial lower with upper", v, 1'b0, 1'b0); // expect 130
  endtask

  task automatic t_bubble();
    logic [255:0] v;
    v = therm(60);  v[30]  = 1'b0;
    runOne("R6 hole low half", v, 1'b0, 1'b0);   // 59
    v = therm(60);  v[90]  = 1'b1;
    runOne("R6 spike low half", v, 1'b0, 1'b0);  // 61
    v = therm(180); v[170] = 1'b0;
    runOne("R6 hole high half", v, 1'b0, 1'b0);  // 179
  endtask

  task automatic t_swap();
    logic [255:0] v;
    v = therm(61); v[60] = 1'b0; v[61] = 1'b1;
    runOne("R10 swapped pair low", v, 1'b0, 1'b0);   // 61
    v = therm(150); v[149] = 1'b0; v[150] = 1'b1;
    runOne("R10 swapped pair high", v, 1'b0, 1'b0);  // 150
  endtask

  task automatic t_range();
    runOne("R7 underflow", therm(5),   1'b1, 1'b0);
    runOne("R8 overflow",  therm(250), 1'b0, 1'b1);
    runOne("R8 both set",  therm(100), 1'b1, 1'b1);
  endtask

  task automatic t_stream();
    logic [255:0] vecs [3];
    vecs[0] = therm(17); vecs[1] = therm(140); vecs[2] = therm(3);
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      if (t >= 3) checkOut($sformatf("R2 stream %0d", t-3), expCode(vecs[t-3], 1'b0, 1'b0), 1'b0, 1'b0, 1'b1);
      if (t < 3) begin
        compIn = vecs[t]; sampleVld = 1'b1;
      end else begin
        compIn = '0; sampleVld = 1'b0;
      end
    end
    @(negedge clk);
    checkOut("R2 stream end", expCode(vecs[2], 1'b0, 1'b0), 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_ideal();
    t_upper();
    t_bubble();
    t_swap();
    t_range();
    t_stream();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule